// File: doc/BRIEF.md
# LCD Controller Instruction Decoder

This block is the device-side command front end of a character and graphic dot-matrix LCD controller. A host presents one byte per transaction together with a register-select flag (`bus_rs`: 0 selects the instruction path, 1 selects the data path) and a direction flag (`bus_rw`: 0 writes, 1 reads). The block decodes instruction bytes from one of two opcode sets. A single extended-mode bit chooses the set. The block also keeps a 7-bit address counter and records which memory the host addressed last: text RAM, user-font RAM, icon RAM or graphic RAM.

Data transactions become a one-cycle RAM write or read strobe. The strobe carries the counter value and the selected memory, and the counter then steps up or down. The block holds the display settings: display, cursor and blink enables, entry direction, display shift offset, graphic enable, sleep, standby, reverse-line choice, and the choice between scroll row and icon address. A status word gives the busy flag and the counter at all times. A cycle counter models busy, and transactions that arrive while busy is high are dropped. The RAM arrays, pixel generation and panel drive are outside this block.

Top module: `lcd_cmd_decoder`

## Requirements
- R1: After reset, `busy`=0, `stat_rdata`=0x00, `addr_inc`=1, `ext_mode`=0, all display, mode and shift outputs are 0, and `ram_sel`=0 (text RAM).
- R2: `stat_rdata` always equals {busy, address counter}, with busy in bit 7 and the counter in bits 6..0. A status read (`bus_rs`=0, `bus_rw`=1) changes no state, does not start busy, and can be made while busy is high.
- R3: Every other accepted transaction holds `busy` high for BUSY_CYC cycles, starting in the cycle after acceptance. The clear instruction holds it for CLEAR_CYC cycles instead. While `busy` is high, every transaction except a status read is ignored.
- R4: In the basic set, an opcode is classified by its highest set bit. `0b00001DCB` sets `disp_on`=D, `cursor_on`=C and `blink_on`=B. `0b000001IS` sets `addr_inc`=I and `entry_shift`=S.
- R5: Basic `0x80|a` loads the counter with a[6:0] and selects text RAM (`ram_sel`=0). Basic `0x40|a` loads the counter with a[5:0] and selects user-font RAM (`ram_sel`=1).
- R6: An accepted data write (read) pulses `ram_we` (`ram_re`) for one cycle in the cycle after acceptance. The pulse carries the old counter on `ram_addr`, the selected memory on `ram_sel` and, for a write, the byte on `ram_wdata`. The counter then moves by +1 when `addr_inc`=1 and by -1 otherwise, modulo 128.
- R7: Clear (basic 0x01) sets the counter and `shift_ofs` to 0 and pulses `clr_req` for one cycle. Home (basic `0x02|x`) also zeroes both values but leaves `clr_req` low.
- R8: Basic `0b0001SR00`: with S=0 the counter moves by one, +1 when R=1 and -1 when R=0. With S=1, `shift_ofs` moves the same way instead (modulo 128) and the counter is left as it was.
- R9: Function set `0b001xxEGx` loads `ext_mode` from bit 2 in either set. Only in the extended set does bit 1 load `gfx_on`.
- R10: Extended 0x01 sets `standby`, and any other accepted instruction write clears it. Extended `0b00001Lxx` sets `sleep_mode`=!L. Extended `0b000001rr` sets `rev_line`=rr. Extended `0b0000001s` sets `scroll_sel`=s.
- R11: Extended `0x40|a`: when `scroll_sel`=1 it loads `scroll_row` with a[5:0] and leaves the counter unchanged. When `scroll_sel`=0 it loads the counter with a[5:0] and selects icon RAM (`ram_sel`=2).
- R12: Extended `0x80|a` is a two-write sequence that selects graphic RAM (`ram_sel`=3). The first write loads `gfx_row` and the counter with a[6:0]. The second loads the counter with a[3:0]. A function set that changes `ext_mode` restarts the sequence at the first (row) write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_valid | input | 1 | One transaction in this cycle |
| bus_rs | input | 1 | 0 instruction path, 1 data path |
| bus_rw | input | 1 | 0 write, 1 read |
| bus_wdata | input | 8 | Instruction or data byte |
| stat_rdata | output | 8 | {busy, address counter} |
| busy | output | 1 | Command in progress |
| ram_we | output | 1 | RAM write strobe |
| ram_re | output | 1 | RAM read strobe |
| ram_sel | output | 2 | Target memory: 0 text, 1 font, 2 icon, 3 graphic |
| ram_addr | output | 7 | RAM address for the strobe |
| ram_wdata | output | 8 | RAM write byte |
| gfx_row | output | 7 | Graphic RAM row |
| clr_req | output | 1 | One-cycle display clear request |
| ext_mode | output | 1 | Extended opcode set active |
| addr_inc | output | 1 | Counter steps upward |
| entry_shift | output | 1 | Display shifts on data write |
| disp_on | output | 1 | Display enabled |
| cursor_on | output | 1 | Cursor shown |
| blink_on | output | 1 | Cursor blinks |
| shift_ofs | output | 7 | Display shift offset |
| gfx_on | output | 1 | Graphic layer enabled |
| sleep_mode | output | 1 | Sleep active |
| standby | output | 1 | Standby active, icons only |
| scroll_sel | output | 1 | 0x40 extended opcode targets scroll row |
| scroll_row | output | 6 | Vertical scroll start row |
| rev_line | output | 2 | Line shown in reverse video |

## Verification
The assertions assume that `bus_valid` is a single-cycle pulse. They also assume that `bus_rs`, `bus_rw` and `bus_wdata` are stable in any cycle where `bus_valid` is high. The counter-step property further relies on `addr_inc` not changing in the same cycle as a data strobe. The bench satisfies all of this by driving inputs only on falling edges and by making every transaction exactly one cycle long. It normally waits for `busy` to fall before issuing a transaction. The only exception is one deliberate transfer made while busy is high, which exercises the drop rule.

// File: rtl/lcd_dec_pkg.sv
package lcd_dec_pkg;
    localparam int unsigned AC_W   = 7;
    localparam int unsigned SROW_W = 6;

    typedef enum logic [1:0] {
        SEL_TEXT = 2'd0,
        SEL_FONT = 2'd1,
        SEL_ICON = 2'd2,
        SEL_GFX  = 2'd3
    } lcd_ram_e;

    typedef enum logic [3:0] {
        OP_NOP, OP_CLEAR, OP_HOME, OP_ENTRY, OP_DISP, OP_SHIFT, OP_FSET,
        OP_FONT_ADDR, OP_TEXT_ADDR, OP_STANDBY, OP_SCRSEL, OP_REV,
        OP_SLEEP, OP_XFSET, OP_ICON_ADDR, OP_GFX_ADDR
    } lcd_op_e;

    typedef struct packed {
        logic [AC_W-1:0]   ac;
        lcd_ram_e          sel;
        logic              inc;
        logic              eshift;
        logic              disp;
        logic              cur;
        logic              blink;
        logic              re;
        logic              gfx;
        logic              sleep;
        logic              stby;
        logic              sr;
        logic              gphase;
        logic [1:0]        rev;
        logic [SROW_W-1:0] srow;
        logic [AC_W-1:0]   grow;
        logic [AC_W-1:0]   shift;
        logic              we;
        logic              rd;
        logic              clr;
        logic [AC_W-1:0]   raddr;
        lcd_ram_e          rsel;
        logic [7:0]        wdata;
    } lcd_state_t;
endpackage

// File: rtl/lcd_op_decode.sv
module lcd_op_decode
    import lcd_dec_pkg::*;
(
    input  logic       ext,
    input  logic [7:0] code,
    output lcd_op_e    op
);
    always_comb begin
        op = OP_NOP;
        if (!ext) begin
            casez (code)
                8'b1???????: op = OP_TEXT_ADDR;
                8'b01??????: op = OP_FONT_ADDR;
                8'b001?????: op = OP_FSET;
                8'b0001????: op = OP_SHIFT;
                8'b00001???: op = OP_DISP;
                8'b000001??: op = OP_ENTRY;
                8'b0000001?: op = OP_HOME;
                8'b00000001: op = OP_CLEAR;
                default:     op = OP_NOP;
            endcase
        end else begin
            casez (code)
                8'b1???????: op = OP_GFX_ADDR;
                8'b01??????: op = OP_ICON_ADDR;
                8'b001?????: op = OP_XFSET;
                8'b0001????: op = OP_NOP;
                8'b00001???: op = OP_SLEEP;
                8'b000001??: op = OP_REV;
                8'b0000001?: op = OP_SCRSEL;
                8'b00000001: op = OP_STANDBY;
                default:     op = OP_NOP;
            endcase
        end
    end
endmodule

// File: rtl/lcd_busy_timer.sv
module lcd_busy_timer #(
    parameter int unsigned SHORT_CYC = 4,
    parameter int unsigned LONG_CYC  = 12
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic long_op,
    output logic busy
);
    localparam int unsigned MAX_CYC = (LONG_CYC > SHORT_CYC) ? LONG_CYC : SHORT_CYC;
    localparam int unsigned CNT_W   = $clog2(MAX_CYC + 1) + 1;

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (start) begin
            cnt_d = long_op ? CNT_W'(LONG_CYC) : CNT_W'(SHORT_CYC);
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - CNT_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign busy = (cnt_q != '0);
endmodule

// File: rtl/lcd_cmd_decoder.sv
module lcd_cmd_decoder
    import lcd_dec_pkg::*;
#(
    parameter int unsigned BUSY_CYC  = 4,
    parameter int unsigned CLEAR_CYC = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_valid,
    input  logic              bus_rs,
    input  logic              bus_rw,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        stat_rdata,
    output logic              busy,
    output logic              ram_we,
    output logic              ram_re,
    output logic [1:0]        ram_sel,
    output logic [AC_W-1:0]   ram_addr,
    output logic [7:0]        ram_wdata,
    output logic [AC_W-1:0]   gfx_row,
    output logic              clr_req,
    output logic              ext_mode,
    output logic              addr_inc,
    output logic              entry_shift,
    output logic              disp_on,
    output logic              cursor_on,
    output logic              blink_on,
    output logic [AC_W-1:0]   shift_ofs,
    output logic              gfx_on,
    output logic              sleep_mode,
    output logic              standby,
    output logic              scroll_sel,
    output logic [SROW_W-1:0] scroll_row,
    output logic [1:0]        rev_line
);
    localparam logic [AC_W-1:0] ONE = AC_W'(1);

    lcd_state_t st_d, st_q;
    lcd_op_e    op;
    logic       acc_cmd, acc_data, long_op;

    assign acc_data = bus_valid && !busy && bus_rs;
    assign acc_cmd  = bus_valid && !busy && !bus_rs && !bus_rw;
    assign long_op  = acc_cmd && (op == OP_CLEAR);

    lcd_op_decode u_dec (
        .ext  (st_q.re),
        .code (bus_wdata),
        .op   (op)
    );

    lcd_busy_timer #(
        .SHORT_CYC (BUSY_CYC),
        .LONG_CYC  (CLEAR_CYC)
    ) u_busy (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (acc_data || acc_cmd),
        .long_op (long_op),
        .busy    (busy)
    );

    always_comb begin
        st_d     = st_q;
        st_d.we  = 1'b0;
        st_d.rd  = 1'b0;
        st_d.clr = 1'b0;
        if (acc_data) begin
            st_d.we    = !bus_rw;
            st_d.rd    = bus_rw;
            st_d.raddr = st_q.ac;
            st_d.rsel  = st_q.sel;
            if (!bus_rw) st_d.wdata = bus_wdata;
            st_d.ac    = st_q.inc ? st_q.ac + ONE : st_q.ac - ONE;
        end
        if (acc_cmd) begin
            st_d.stby = 1'b0;
            case (op)
                OP_CLEAR: begin
                    st_d.ac    = '0;
                    st_d.shift = '0;
                    st_d.clr   = 1'b1;
                end
                OP_HOME: begin
                    st_d.ac    = '0;
                    st_d.shift = '0;
                end
                OP_ENTRY: begin
                    st_d.inc    = bus_wdata[1];
                    st_d.eshift = bus_wdata[0];
                end
                OP_DISP: begin
                    st_d.disp  = bus_wdata[2];
                    st_d.cur   = bus_wdata[1];
                    st_d.blink = bus_wdata[0];
                end
                OP_SHIFT: begin
                    if (bus_wdata[3])
                        st_d.shift = bus_wdata[2] ? st_q.shift + ONE : st_q.shift - ONE;
                    else
                        st_d.ac = bus_wdata[2] ? st_q.ac + ONE : st_q.ac - ONE;
                end
                OP_FSET, OP_XFSET: begin
                    st_d.re = bus_wdata[2];
                    if (bus_wdata[2] != st_q.re) st_d.gphase = 1'b0;
                    if (op == OP_XFSET) st_d.gfx = bus_wdata[1];
                end
                OP_TEXT_ADDR: begin
                    st_d.ac  = bus_wdata[AC_W-1:0];
                    st_d.sel = SEL_TEXT;
                end
                OP_FONT_ADDR: begin
                    st_d.ac  = AC_W'(bus_wdata[5:0]);
                    st_d.sel = SEL_FONT;
                end
                OP_STANDBY: st_d.stby  = 1'b1;
                OP_SCRSEL:  st_d.sr    = bus_wdata[0];
                OP_REV:     st_d.rev   = bus_wdata[1:0];
                OP_SLEEP:   st_d.sleep = !bus_wdata[2];
                OP_ICON_ADDR: begin
                    if (st_q.sr) begin
                        st_d.srow = bus_wdata[SROW_W-1:0];
                    end else begin
                        st_d.ac  = AC_W'(bus_wdata[5:0]);
                        st_d.sel = SEL_ICON;
                    end
                end
                OP_GFX_ADDR: begin
                    st_d.sel    = SEL_GFX;
                    st_d.gphase = !st_q.gphase;
                    if (!st_q.gphase) begin
                        st_d.grow = bus_wdata[AC_W-1:0];
                        st_d.ac   = bus_wdata[AC_W-1:0];
                    end else begin
                        st_d.ac = AC_W'(bus_wdata[3:0]);
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q     <= '0;
            st_q.inc <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign stat_rdata  = {busy, st_q.ac};
    assign ram_we      = st_q.we;
    assign ram_re      = st_q.rd;
    assign ram_sel     = st_q.rsel;
    assign ram_addr    = st_q.raddr;
    assign ram_wdata   = st_q.wdata;
    assign gfx_row     = st_q.grow;
    assign clr_req     = st_q.clr;
    assign ext_mode    = st_q.re;
    assign addr_inc    = st_q.inc;
    assign entry_shift = st_q.eshift;
    assign disp_on     = st_q.disp;
    assign cursor_on   = st_q.cur;
    assign blink_on    = st_q.blink;
    assign shift_ofs   = st_q.shift;
    assign gfx_on      = st_q.gfx;
    assign sleep_mode  = st_q.sleep;
    assign standby     = st_q.stby;
    assign scroll_sel  = st_q.sr;
    assign scroll_row  = st_q.srow;
    assign rev_line    = st_q.rev;
endmodule

// File: rtl/lcd_cmd_decoder_chk.sv
module lcd_cmd_decoder_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       bus_valid,
    input logic       bus_rs,
    input logic       bus_rw,
    input logic [7:0] bus_wdata,
    input logic       busy,
    input logic [7:0] stat_rdata,
    input logic       ram_we,
    input logic       ram_re,
    input logic [6:0] ram_addr,
    input logic       clr_req,
    input logic       addr_inc,
    input logic       ext_mode,
    input logic       standby
);
    // R3: an accepted non-status transaction raises busy on the next cycle
    p_busy_start_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && !busy && !(!bus_rs && bus_rw)) |=> busy);

    // R3: transfers offered while busy produce no strobe
    p_drop_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && busy) |=> !(ram_we || ram_re || clr_req));

    // R6: the strobe carries the counter value it was accepted with
    p_strobe_addr_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (ram_we || ram_re) |-> (ram_addr == $past(stat_rdata[6:0])));

    // R6: the counter has stepped once after a strobe
    p_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (ram_we || ram_re) |-> (stat_rdata[6:0] == (addr_inc ? ram_addr + 7'd1 : ram_addr - 7'd1)));

    // R6: never write and read at once
    p_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(ram_we && ram_re));

    // R7: a clear request comes with a zero counter and busy
    p_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        clr_req |-> (stat_rdata[6:0] == 7'd0 && stat_rdata[7]));

    // R10: standby entered by its own opcode in the extended set
    p_stby_set_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (ext_mode && bus_valid && !busy && !bus_rs && !bus_rw && bus_wdata == 8'h01) |=> standby);

    // R10: any other accepted instruction write leaves standby
    p_stby_exit_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && !busy && !bus_rs && !bus_rw && !(ext_mode && bus_wdata == 8'h01)) |=> !standby);
endmodule

bind lcd_cmd_decoder lcd_cmd_decoder_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_valid  (bus_valid),
    .bus_rs     (bus_rs),
    .bus_rw     (bus_rw),
    .bus_wdata  (bus_wdata),
    .busy       (busy),
    .stat_rdata (stat_rdata),
    .ram_we     (ram_we),
    .ram_re     (ram_re),
    .ram_addr   (ram_addr),
    .clr_req    (clr_req),
    .addr_inc   (addr_inc),
    .ext_mode   (ext_mode),
    .standby    (standby)
);

// File: tb/lcd_cmd_decoder_tb_top.sv
`timescale 1ns/1ps
module lcd_cmd_decoder_tb_top;
    localparam int BCYC = 3;
    localparam int CCYC = 9;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bus_valid = 1'b0, bus_rs = 1'b0, bus_rw = 1'b0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] stat_rdata, ram_wdata;
    logic busy, ram_we, ram_re, clr_req, ext_mode, addr_inc, entry_shift;
    logic disp_on, cursor_on, blink_on, gfx_on, sleep_mode, standby, scroll_sel;
    logic [1:0] ram_sel, rev_line;
    logic [6:0] ram_addr, gfx_row, shift_ofs;
    logic [5:0] scroll_row;

    int tests = 0;
    int fails = 0;
    bit done = 0;

    always #4 clk = ~clk;

    lcd_cmd_decoder #(.BUSY_CYC(BCYC), .CLEAR_CYC(CCYC)) dut_i (
        .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_rs(bus_rs),
        .bus_rw(bus_rw), .bus_wdata(bus_wdata), .stat_rdata(stat_rdata),
        .busy(busy), .ram_we(ram_we), .ram_re(ram_re), .ram_sel(ram_sel),
        .ram_addr(ram_addr), .ram_wdata(ram_wdata), .gfx_row(gfx_row),
        .clr_req(clr_req), .ext_mode(ext_mode), .addr_inc(addr_inc),
        .entry_shift(entry_shift), .disp_on(disp_on), .cursor_on(cursor_on),
        .blink_on(blink_on), .shift_ofs(shift_ofs), .gfx_on(gfx_on),
        .sleep_mode(sleep_mode), .standby(standby), .scroll_sel(scroll_sel),
        .scroll_row(scroll_row), .rev_line(rev_line)
    );

    // behavioural reference model
    int m_cnt, m_ac, m_sel, m_shift, m_grow, m_srow, m_rev, m_raddr, m_rsel, m_wdata;
    bit m_inc, m_es, m_disp, m_cur, m_blink, m_ext, m_gfx, m_sleep, m_stby, m_sr, m_ph;
    bit m_we, m_re, m_clr;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_cnt = 0; m_ac = 0; m_sel = 0; m_shift = 0; m_grow = 0; m_srow = 0;
            m_rev = 0; m_raddr = 0; m_rsel = 0; m_wdata = 0; m_inc = 1; m_es = 0;
            m_disp = 0; m_cur = 0; m_blink = 0; m_ext = 0; m_gfx = 0; m_sleep = 0;
            m_stby = 0; m_sr = 0; m_ph = 0; m_we = 0; m_re = 0; m_clr = 0;
        end else begin
            int nc;
            int h;
            bit acc;
            m_we = 0; m_re = 0; m_clr = 0;
            acc = bus_valid && (m_cnt == 0);
            nc = (m_cnt > 0) ? m_cnt - 1 : 0;
            if (acc && bus_rs) begin
                if (bus_rw) m_re = 1; else begin m_we = 1; m_wdata = bus_wdata; end
                m_raddr = m_ac; m_rsel = m_sel;
                m_ac = (m_ac + (m_inc ? 1 : 127)) % 128;
                nc = BCYC;
            end else if (acc && !bus_rw) begin
                h = -1;
                for (int i = 0; i < 8; i++) if (bus_wdata[i]) h = i;
                nc = (!m_ext && h == 0) ? CCYC : BCYC;
                m_stby = m_ext && (h == 0);
                if (!m_ext) begin
                    case (h)
                        7: begin m_ac = bus_wdata % 128; m_sel = 0; end
                        6: begin m_ac = bus_wdata % 64; m_sel = 1; end
                        5: begin if (bus_wdata[2] != m_ext) m_ph = 0; m_ext = bus_wdata[2]; end
                        4: begin
                            if (bus_wdata[3]) m_shift = (m_shift + (bus_wdata[2] ? 1 : 127)) % 128;
                            else              m_ac = (m_ac + (bus_wdata[2] ? 1 : 127)) % 128;
                        end
                        3: begin m_disp = bus_wdata[2]; m_cur = bus_wdata[1]; m_blink = bus_wdata[0]; end
                        2: begin m_inc = bus_wdata[1]; m_es = bus_wdata[0]; end
                        1: begin m_ac = 0; m_shift = 0; end
                        0: begin m_ac = 0; m_shift = 0; m_clr = 1; end
                        default: ;
                    endcase
                end else begin
                    case (h)
                        7: begin
                            m_sel = 3;
                            if (!m_ph) begin m_grow = bus_wdata % 128; m_ac = m_grow; end
                            else m_ac = bus_wdata % 16;
                            m_ph = !m_ph;
                        end
                        6: if (m_sr) m_srow = bus_wdata % 64; else begin m_ac = bus_wdata % 64; m_sel = 2; end
                        5: begin
                            if (bus_wdata[2] != m_ext) m_ph = 0;
                            m_ext = bus_wdata[2]; m_gfx = bus_wdata[1];
                        end
                        3: m_sleep = !bus_wdata[2];
                        2: m_rev = bus_wdata % 4;
                        1: m_sr = bus_wdata[0];
                        default: ;
                    endcase
                end
            end
            m_cnt = nc;
        end
    end

    function automatic logic [79:0] pack_dut();
        return {8'(stat_rdata), 1'(busy), 1'(ram_we), 1'(ram_re), 2'(ram_sel), 7'(ram_addr),
                8'(ram_wdata), 7'(gfx_row), 1'(clr_req), 1'(ext_mode), 1'(addr_inc),
                1'(entry_shift), 1'(disp_on), 1'(cursor_on), 1'(blink_on), 7'(shift_ofs),
                1'(gfx_on), 1'(sleep_mode), 1'(standby), 1'(scroll_sel), 6'(scroll_row),
                2'(rev_line), 12'd0};
    endfunction

    function automatic logic [79:0] pack_model();
        return {1'(m_cnt != 0), 7'(m_ac), 1'(m_cnt != 0), 1'(m_we), 1'(m_re), 2'(m_rsel),
                7'(m_raddr), 8'(m_wdata), 7'(m_grow), 1'(m_clr), 1'(m_ext), 1'(m_inc),
                1'(m_es), 1'(m_disp), 1'(m_cur), 1'(m_blink), 7'(m_shift), 1'(m_gfx),
                1'(m_sleep), 1'(m_stby), 1'(m_sr), 6'(m_srow), 2'(m_rev), 12'd0};
    endfunction

    // every-cycle comparison against the model (R2 status word, R3 busy, R6 strobes)
    always @(negedge clk) begin
        if (rst_n && !done) begin
            tests++;
            if (pack_dut() !== pack_model()) begin
                fails++;
                $display("FAIL R2/R3/R6 model compare at %0t: actual %h expected %h",
                         $time, pack_dut(), pack_model());
            end
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic rs, input logic rw, input logic [7:0] d);
        while (busy) @(negedge clk);
        bus_rs = rs; bus_rw = rw; bus_wdata = d; bus_valid = 1'b1;
        @(negedge clk);
        bus_valid = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            done = 1;
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        int n;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 status", stat_rdata, 8'h00);
        chk("R1 inc", addr_inc, 1);
        chk("R1 flags", {ext_mode, disp_on, gfx_on, standby, sleep_mode, ram_sel}, 0);

        wr(0, 0, 8'h0F);
        chk("R4 disp/cur/blink", {disp_on, cursor_on, blink_on}, 3'b111);
        n = 0;
        while (busy) begin n++; @(negedge clk); end
        chk("R3 busy length", n, BCYC);

        wr(0, 0, 8'h90);
        chk("R5 text addr", stat_rdata[6:0], 7'h10);
        bus_rs = 1; bus_rw = 0; bus_wdata = 8'h77; bus_valid = 1;
        @(negedge clk); bus_valid = 0;
        chk("R3 drop while busy", {ram_we, stat_rdata[6:0]}, {1'b0, 7'h10});
        bus_rs = 0; bus_rw = 1; bus_valid = 1;
        @(negedge clk); bus_valid = 0;
        chk("R2 status while busy", stat_rdata, 8'h90);

        wr(1, 0, 8'hA5);
        chk("R6 write strobe", {ram_we, ram_sel, ram_addr, ram_wdata}, {1'b1, 2'd0, 7'h10, 8'hA5});
        chk("R6 increment", stat_rdata[6:0], 7'h11);

        wr(0, 0, 8'h04);
        chk("R4 entry dec", {addr_inc, entry_shift}, 2'b00);
        wr(1, 1, 8'h00);
        chk("R6 read strobe", {ram_re, ram_we, ram_addr}, {2'b10, 7'h11});
        chk("R6 decrement", stat_rdata[6:0], 7'h10);

        wr(0, 0, 8'h07);
        wr(0, 0, 8'hFF);
        wr(1, 0, 8'h3C);
        chk("R6 wrap", {ram_addr, stat_rdata[6:0]}, {7'h7F, 7'h00});

        wr(0, 0, 8'h45);
        wr(1, 0, 8'h11);
        chk("R5 font addr", {ram_sel, ram_addr}, {2'd1, 7'h05});

        wr(0, 0, 8'h14);
        chk("R8 cursor right", stat_rdata[6:0], 7'h07);
        wr(0, 0, 8'h18);
        chk("R8 display left", {shift_ofs, stat_rdata[6:0]}, {7'h7F, 7'h07});

        wr(0, 0, 8'h03);
        chk("R7 home", {shift_ofs, stat_rdata[6:0], clr_req}, 15'd0);
        wr(0, 0, 8'hA2);
        wr(0, 0, 8'h01);
        chk("R7 clear", {clr_req, stat_rdata}, {1'b1, 8'h80});
        n = 0;
        while (busy) begin n++; @(negedge clk); end
        chk("R3 clear busy length", n, CCYC);

        wr(0, 0, 8'h26);
        chk("R9 basic fset", {ext_mode, gfx_on}, 2'b10);
        wr(0, 0, 8'h26);
        chk("R9 ext fset", {ext_mode, gfx_on}, 2'b11);

        wr(0, 0, 8'h01);
        chk("R10 standby", standby, 1);
        wr(0, 0, 8'h08);
        chk("R10 sleep, standby exit", {sleep_mode, standby}, 2'b10);
        wr(0, 0, 8'h0C);
        wr(0, 0, 8'h07);
        chk("R10 wake, rev", {sleep_mode, rev_line}, 3'b011);
        wr(0, 0, 8'h03);
        chk("R10 scroll sel", scroll_sel, 1);

        wr(0, 0, 8'h55);
        chk("R11 scroll row", {scroll_row, stat_rdata[6:0]}, {6'h15, 7'h00});
        wr(0, 0, 8'h02);
        wr(0, 0, 8'h4A);
        wr(1, 0, 8'h99);
        chk("R11 icon addr", {ram_sel, ram_addr}, {2'd2, 7'h0A});

        wr(0, 0, 8'hA1);
        chk("R12 row write", {gfx_row, stat_rdata[6:0]}, {7'h21, 7'h21});
        wr(0, 0, 8'h85);
        chk("R12 column write", stat_rdata[6:0], 7'h05);
        wr(1, 0, 8'h5A);
        chk("R12 gfx strobe", {ram_sel, ram_addr, gfx_row}, {2'd3, 7'h05, 7'h21});
        wr(0, 0, 8'h92);
        wr(0, 0, 8'h20);
        wr(0, 0, 8'h24);
        wr(0, 0, 8'h87);
        chk("R12 phase restart", gfx_row, 7'h07);

        repeat (12) @(negedge clk);
        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule